// File: doc/BRIEF.md
# Fast-Command Decoder with Per-Command Alignment Delays

This block sits behind the fast-control link of a detector front end. On every bunch-crossing clock cycle it takes one 24-bit command word. It splits the word into the crossing number the word was sent for and a set of commands. The commands are synchronization, full-readout (non-suppressed) mode, suppress (header-only or crossing veto), crossing-counter reset, front-end reset, a calibration type and snapshot. The link delivers every line with the same latency, and commands leave the sender a fixed number of cycles before the crossing they act on. The block therefore passes each command through its own delay line, set from 0 to 31 cycles, so that it reaches the local logic at the right crossing.

Each delay line carries the crossing number of the word along with the command, so every output strobe is tagged with its crossing. When a delay value changes, only words that enter afterwards are affected. Words already inside the line still leave at the cycle fixed when they entered. If two words then fall due together, their commands are merged.

A local 12-bit crossing counter runs freely and restarts from the delayed crossing-counter reset. From then on, the crossing number arriving in that lane is compared with the counter every cycle. A sticky flag records any difference.

Top module: `fcd_cmd_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, every strobe, `o_calib`, `o_tag_vld` and `o_mismatch` become 0 and `o_bx_local` becomes 0.
- R2: Word layout: bits 23..12 crossing number; bit 11 synch, bit 10 full-readout mode, bit 9 header-only, bit 8 counter reset, bit 7 front-end reset, bits 6..3 calibration type, bit 2 crossing veto, bit 1 snapshot, bit 0 reserved. Each command drives only its own output, and bit 0 affects no output.
- R3: Lanes are indexed synch 0, full-readout 1, suppress 2, counter reset 3, front-end reset 4, calibration 5, snapshot 6. The delay of lane i is `cfg_delay[5i+4:5i]`. A word sampled at clock edge n with delay D for a lane appears on that lane's outputs after edge n+D, for D from 0 to 31.
- R4: Header-only and crossing veto share one lane and one delay, and `o_suppress` is their OR.
- R5: Whenever a lane presents a word, `o_tag[12i+11:12i]` holds the crossing number (bits 23..12) of that word.
- R6: A lane's delay is sampled when a word enters the lane. A change of delay does not move words already inside the line. When two words fall due on the same edge, their command bits are ORed and the later word's crossing number is kept. On an edge where no word falls due, `o_tag_vld[i]` is 0 and the lane's commands are 0.
- R7: `o_bx_local` advances by one (modulo 4096) on every edge. On the cycle the delayed counter-reset strobe is out, it reads 0, and it continues from 1.
- R8: After the first delayed counter reset, `o_mismatch` sets on the edge following any cycle in which the reset lane presents a word, its strobe is low, and its crossing number differs from `o_bx_local`. It then stays set until `rst_n`.
- R9: A synch command held on consecutive words gives `o_synch` high on the same number of consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word | input | 24 | Fast-command word, one per cycle |
| cfg_delay | input | 35 | Seven 5-bit delays, lane i at bits 5i+4..5i |
| o_synch | output | 1 | Delayed synch strobe |
| o_nzs | output | 1 | Delayed full-readout mode strobe |
| o_suppress | output | 1 | Delayed header-only or veto strobe |
| o_bxrst | output | 1 | Delayed crossing-counter reset strobe |
| o_fereset | output | 1 | Delayed front-end reset strobe |
| o_calib | output | 4 | Delayed calibration type, 0 when none |
| o_snapshot | output | 1 | Delayed snapshot strobe |
| o_tag | output | 84 | Crossing number per lane, lane i at bits 12i+11..12i |
| o_tag_vld | output | 7 | Per lane: a word is presented this cycle |
| o_bx_local | output | 12 | Local crossing counter |
| o_mismatch | output | 1 | Sticky crossing-number mismatch flag |

## Verification
A corrupted slot valid bit or payload in a delay line becomes visible at the ports the next time the read position passes that slot, which is at most 32 cycles later. It shows as an extra or missing `o_tag_vld` bit, a wrong strobe or a wrong tag. A delay applied at the read side instead of the write side shows up on the first edge after a delay change, as duplicated or lost commands. A wrong crossing counter state is visible on `o_bx_local` in the same cycle. Once the counter is armed, it also raises `o_mismatch` one edge later, and the flag then stays high. The reference model predicts every output on every cycle, so the first such deviation is reported on the cycle it appears.

// File: rtl/fcd_pkg.sv
// Shared constants for the fast-command decoder.
// Assumes a 12-bit command field below the crossing number in each word.
package fcd_pkg;

    // Command field width and bit positions inside the low part of a word
    localparam int CMD_BITS   = 12;
    localparam int POS_SYNCH  = 11;
    localparam int POS_NZS    = 10;
    localparam int POS_HDR    = 9;
    localparam int POS_BXRST  = 8;
    localparam int POS_FERST  = 7;
    localparam int POS_CAL_LO = 3;
    localparam int CAL_W      = 4;
    localparam int POS_VETO   = 2;
    localparam int POS_SNAP   = 1;
    localparam int POS_RSVD   = 0;

    // Delay lanes, one per command (header-only and veto share one)
    localparam int L_SYNCH = 0;
    localparam int L_NZS   = 1;
    localparam int L_SUPP  = 2;
    localparam int L_BXRST = 3;
    localparam int L_FERST = 4;
    localparam int L_CALIB = 5;
    localparam int L_SNAP  = 6;
    localparam int NLANE   = 7;

    // Widest lane payload
    localparam int LANE_DMAX = CAL_W;

    // Payload width carried by a lane
    function automatic int lane_width(input int lane);
        return (lane == L_CALIB) ? CAL_W : 1;
    endfunction

endpackage

// File: rtl/fcd_field_split.sv
// Splits a fast-command word into its crossing number and per-lane payloads.
// Purely combinational. Header-only and veto are merged here into one lane.
// The reserved bit is deliberately dropped.
module fcd_field_split
    import fcd_pkg::*;
#(
    parameter int BX_W = 12,
    localparam int WORD_W = BX_W + CMD_BITS
) (
    input  logic [WORD_W-1:0]                   cmd_word,
    output logic [BX_W-1:0]                     bx_id,
    output logic [NLANE-1:0][LANE_DMAX-1:0]     lane_data
);

    logic unused_rsvd;

    assign bx_id       = cmd_word[WORD_W-1 -: BX_W];
    assign unused_rsvd = cmd_word[POS_RSVD];

    // Route each command field onto its lane payload
    always_comb begin
        lane_data             = '0;
        lane_data[L_SYNCH][0] = cmd_word[POS_SYNCH];
        lane_data[L_NZS][0]   = cmd_word[POS_NZS];
        lane_data[L_SUPP][0]  = cmd_word[POS_HDR] | cmd_word[POS_VETO];
        lane_data[L_BXRST][0] = cmd_word[POS_BXRST];
        lane_data[L_FERST][0] = cmd_word[POS_FERST];
        lane_data[L_CALIB]    = cmd_word[POS_CAL_LO +: CAL_W];
        lane_data[L_SNAP][0]  = cmd_word[POS_SNAP];
    end

endmodule

// File: rtl/fcd_delay_lane.sv
// Programmable delay line for one command lane, 0 .. 2**DLY_W-1 cycles.
// Words are scheduled on entry: a word is written into the slot that the
// read pointer will reach after 'delay' edges. A later delay change
// therefore never moves a word already in flight. Colliding words are
// merged: payload ORed, newest tag kept. Delay 0 bypasses the ring into the
// output register. Assumes one word enters every cycle.
module fcd_delay_lane #(
    parameter int DATA_W = 1,
    parameter int TAG_W  = 12,
    parameter int DLY_W  = 5,
    localparam int DEPTH = 1 << DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  delay,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);

    logic [DLY_W-1:0]  rd_ptr;
    logic [DLY_W-1:0]  wr_idx;
    logic [DEPTH-1:0]  slot_vld;
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [TAG_W-1:0]  slot_tag  [DEPTH];
    logic              bypass;
    logic              nxt_vld;
    logic [DATA_W-1:0] nxt_data;
    logic [TAG_W-1:0]  nxt_tag;
    logic [DATA_W-1:0] wr_data;

    assign wr_idx = rd_ptr + delay;
    assign bypass = (delay == '0);

    // Select what leaves the line on this edge, merging a zero-delay word
    always_comb begin
        nxt_vld  = slot_vld[rd_ptr];
        nxt_data = slot_vld[rd_ptr] ? slot_data[rd_ptr] : '0;
        nxt_tag  = slot_tag[rd_ptr];
        if (bypass) begin
            nxt_vld  = 1'b1;
            nxt_data = nxt_data | in_data;
            nxt_tag  = in_tag;
        end
    end

    // Merge the incoming payload with a word already due in the same slot
    always_comb begin
        wr_data = slot_vld[wr_idx] ? (slot_data[wr_idx] | in_data) : in_data;
    end

    // Control state: read pointer, slot occupancy and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            slot_vld <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            out_tag  <= '0;
        end else begin
            rd_ptr           <= rd_ptr + DLY_W'(1);
            slot_vld[rd_ptr] <= 1'b0;
            if (!bypass) begin
                slot_vld[wr_idx] <= 1'b1;
            end
            out_vld  <= nxt_vld;
            out_data <= nxt_vld ? nxt_data : '0;
            out_tag  <= nxt_vld ? nxt_tag : '0;
        end
    end

    // Payload storage, written only at the scheduled slot
    always_ff @(posedge clk) begin
        if (!bypass) begin
            slot_data[wr_idx] <= wr_data;
            slot_tag[wr_idx]  <= in_tag;
        end
    end

endmodule

// File: rtl/fcd_bx_tracker.sv
// Local crossing counter and consistency monitor.
// Counts every cycle. The delayed counter-reset strobe marks crossing 0, so
// the count restarts at 1 on the next cycle. After the first such reset,
// every presented word whose tag disagrees with the count sets a sticky
// flag. The reset cycle itself is not compared.
module fcd_bx_tracker #(
    parameter int BX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_vld,
    input  logic            ref_reset,
    input  logic [BX_W-1:0] ref_tag,
    output logic [BX_W-1:0] bx_local,
    output logic            mismatch
);

    logic [BX_W-1:0] cnt_q;
    logic            armed_q;
    logic            mism_q;

    // Counter, arming and sticky mismatch update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            mism_q  <= 1'b0;
        end else begin
            if (ref_reset) begin
                cnt_q   <= BX_W'(1);
                armed_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + BX_W'(1);
            end
            if (armed_q && ref_vld && !ref_reset && (ref_tag != cnt_q)) begin
                mism_q <= 1'b1;
            end
        end
    end

    assign bx_local = ref_reset ? '0 : cnt_q;
    assign mismatch = mism_q;

endmodule

// File: rtl/fcd_cmd_aligner.sv
// Top of the fast-command decoder: splits each word, delays every command
// lane by its own programmable amount with the crossing number riding
// along, and tracks a local crossing counter against the reset lane.
// Assumes one command word per clock and a delay configuration held by an
// outside register bank.
module fcd_cmd_aligner
    import fcd_pkg::*;
#(
    parameter int BX_W  = 12,
    parameter int DLY_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BX_W+CMD_BITS-1:0] cmd_word,
    input  logic [NLANE*DLY_W-1:0]   cfg_delay,
    output logic                     o_synch,
    output logic                     o_nzs,
    output logic                     o_suppress,
    output logic                     o_bxrst,
    output logic                     o_fereset,
    output logic [CAL_W-1:0]         o_calib,
    output logic                     o_snapshot,
    output logic [NLANE*BX_W-1:0]    o_tag,
    output logic [NLANE-1:0]         o_tag_vld,
    output logic [BX_W-1:0]          o_bx_local,
    output logic                     o_mismatch
);

    logic [BX_W-1:0]                 bx_id;
    logic [NLANE-1:0][LANE_DMAX-1:0] lane_in;
    logic [NLANE-1:0][LANE_DMAX-1:0] lane_out;
    logic [NLANE-1:0][BX_W-1:0]      lane_tag;
    logic [NLANE-1:0]                lane_vld;
    logic                            unused_pad;

    fcd_field_split #(.BX_W(BX_W)) u_split (
        .cmd_word  (cmd_word),
        .bx_id     (bx_id),
        .lane_data (lane_in)
    );

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        localparam int LW = lane_width(gi);
        logic [LW-1:0] ld;

        fcd_delay_lane #(
            .DATA_W (LW),
            .TAG_W  (BX_W),
            .DLY_W  (DLY_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .delay    (cfg_delay[gi*DLY_W +: DLY_W]),
            .in_data  (lane_in[gi][LW-1:0]),
            .in_tag   (bx_id),
            .out_vld  (lane_vld[gi]),
            .out_data (ld),
            .out_tag  (lane_tag[gi])
        );

        assign lane_out[gi] = LANE_DMAX'(ld);
    end

    assign o_synch    = lane_vld[L_SYNCH] & lane_out[L_SYNCH][0];
    assign o_nzs      = lane_vld[L_NZS]   & lane_out[L_NZS][0];
    assign o_suppress = lane_vld[L_SUPP]  & lane_out[L_SUPP][0];
    assign o_bxrst    = lane_vld[L_BXRST] & lane_out[L_BXRST][0];
    assign o_fereset  = lane_vld[L_FERST] & lane_out[L_FERST][0];
    assign o_snapshot = lane_vld[L_SNAP]  & lane_out[L_SNAP][0];
    assign o_calib    = lane_vld[L_CALIB] ? lane_out[L_CALIB][CAL_W-1:0] : '0;
    assign o_tag      = lane_tag;
    assign o_tag_vld  = lane_vld;
    assign unused_pad = ^{lane_in, lane_out};

    fcd_bx_tracker #(.BX_W(BX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_vld   (lane_vld[L_BXRST]),
        .ref_reset (o_bxrst),
        .ref_tag   (lane_tag[L_BXRST]),
        .bx_local  (o_bx_local),
        .mismatch  (o_mismatch)
    );

endmodule

// File: rtl/fcd_cmd_aligner_chk.sv
// Property checker for fcd_cmd_aligner, attached through bind.
// Observes ports only.
module fcd_cmd_aligner_chk
    import fcd_pkg::*;
#(
    parameter int BX_W  = 12,
    parameter int DLY_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [BX_W+CMD_BITS-1:0] cmd_word,
    input logic [NLANE*DLY_W-1:0]   cfg_delay,
    input logic                     o_synch,
    input logic                     o_suppress,
    input logic                     o_bxrst,
    input logic [NLANE*BX_W-1:0]    o_tag,
    input logic [NLANE-1:0]         o_tag_vld,
    input logic [BX_W-1:0]          o_bx_local,
    input logic                     o_mismatch
);

    localparam int WORD_W = BX_W + CMD_BITS;

    logic [DLY_W-1:0] synch_dly;
    logic [DLY_W-1:0] supp_dly;
    logic [BX_W-1:0]  synch_tag;
    logic [BX_W-1:0]  rst_tag;

    assign synch_dly = cfg_delay[L_SYNCH*DLY_W +: DLY_W];
    assign supp_dly  = cfg_delay[L_SUPP*DLY_W +: DLY_W];
    assign synch_tag = o_tag[L_SYNCH*BX_W +: BX_W];
    assign rst_tag   = o_tag[L_BXRST*BX_W +: BX_W];

    AST_SYNCH_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[POS_SYNCH] && synch_dly == '0) |=> o_synch);  // R9

    AST_TAG_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (synch_dly == '0) |=> (o_tag_vld[L_SYNCH] &&
                               synch_tag == $past(cmd_word[WORD_W-1 -: BX_W])));  // R5

    AST_VETO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[POS_VETO] && supp_dly == '0) |=> o_suppress);  // R4

    AST_BX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (o_bxrst ? (o_bx_local == '0)
                          : (o_bx_local == BX_W'($past(o_bx_local) + 1'b1))));  // R7

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        o_mismatch |=> o_mismatch);  // R8

    AST_MISMATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_mismatch) |-> $past(o_tag_vld[L_BXRST] && !o_bxrst &&
                                    (rst_tag != o_bx_local)));  // R8

endmodule

bind fcd_cmd_aligner fcd_cmd_aligner_chk #(
    .BX_W  (BX_W),
    .DLY_W (DLY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_word   (cmd_word),
    .cfg_delay  (cfg_delay),
    .o_synch    (o_synch),
    .o_suppress (o_suppress),
    .o_bxrst    (o_bxrst),
    .o_tag      (o_tag),
    .o_tag_vld  (o_tag_vld),
    .o_bx_local (o_bx_local),
    .o_mismatch (o_mismatch)
);

// File: tb/tb_fcd_cmd_aligner.sv
// Self-checking bench: a behavioural model (due-cycle bookkeeping per lane,
// integer counter) predicts every output and is compared on every clock.
module tb_fcd_cmd_aligner;
    import fcd_pkg::*;

    localparam int BX_W   = 12;
    localparam int DLY_W  = 5;
    localparam int WORD_W = BX_W + CMD_BITS;
    localparam int NL     = NLANE;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [WORD_W-1:0]      cmd_word = '0;
    logic [NL*DLY_W-1:0]    cfg_delay = '0;
    logic                   o_synch, o_nzs, o_suppress, o_bxrst, o_fereset, o_snapshot;
    logic [CAL_W-1:0]       o_calib;
    logic [NL*BX_W-1:0]     o_tag;
    logic [NL-1:0]          o_tag_vld;
    logic [BX_W-1:0]        o_bx_local;
    logic                   o_mismatch;

    always #5 clk = ~clk;

    fcd_cmd_aligner #(.BX_W(BX_W), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cfg_delay(cfg_delay),
        .o_synch(o_synch), .o_nzs(o_nzs), .o_suppress(o_suppress), .o_bxrst(o_bxrst),
        .o_fereset(o_fereset), .o_calib(o_calib), .o_snapshot(o_snapshot),
        .o_tag(o_tag), .o_tag_vld(o_tag_vld), .o_bx_local(o_bx_local),
        .o_mismatch(o_mismatch)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int m_dat [NL][64];
    int m_tag [NL][64];
    int m_due [NL][64];
    bit m_pres[NL][64];
    bit m_ov [NL];
    int m_od [NL];
    int m_ot [NL];
    int m_cyc, m_cnt, m_bx;
    bit m_armed, m_mis;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Command value of one lane as defined by the word layout
    function automatic int lane_val(input logic [WORD_W-1:0] w, input int l);
        case (l)
            L_SYNCH: return int'(w[11]);
            L_NZS:   return int'(w[10]);
            L_SUPP:  return int'(w[9] | w[2]);
            L_BXRST: return int'(w[8]);
            L_FERST: return int'(w[7]);
            L_CALIB: return int'(w[6:3]);
            default: return int'(w[1]);
        endcase
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NL; l++) begin
            for (int k = 0; k < 64; k++) m_pres[l][k] = 1'b0;
            m_ov[l] = 1'b0; m_od[l] = 0; m_ot[l] = 0;
        end
        m_cyc = 0; m_cnt = 0; m_bx = 0; m_armed = 1'b0; m_mis = 1'b0;
    endtask

    task automatic model_edge(input logic [WORD_W-1:0] w);
        bit old_s;
        old_s = m_ov[L_BXRST] && (m_od[L_BXRST] != 0);
        if (m_armed && m_ov[L_BXRST] && !old_s && (m_ot[L_BXRST] != m_cnt)) m_mis = 1'b1;
        if (old_s) begin m_cnt = 1; m_armed = 1'b1; end
        else m_cnt = (m_cnt + 1) % (1 << BX_W);
        for (int l = 0; l < NL; l++) begin
            int due, k;
            due = m_cyc + int'(cfg_delay[l*DLY_W +: DLY_W]);
            k = due % 64;
            if (m_pres[l][k] && m_due[l][k] == due) begin
                m_dat[l][k] = m_dat[l][k] | lane_val(w, l);
                m_tag[l][k] = int'(w[WORD_W-1 -: BX_W]);
            end else begin
                m_pres[l][k] = 1'b1; m_due[l][k] = due;
                m_dat[l][k] = lane_val(w, l);
                m_tag[l][k] = int'(w[WORD_W-1 -: BX_W]);
            end
        end
        for (int l = 0; l < NL; l++) begin
            int k;
            k = m_cyc % 64;
            if (m_pres[l][k] && m_due[l][k] == m_cyc) begin
                m_ov[l] = 1'b1; m_od[l] = m_dat[l][k]; m_ot[l] = m_tag[l][k];
                m_pres[l][k] = 1'b0;
            end else begin
                m_ov[l] = 1'b0; m_od[l] = 0; m_ot[l] = 0;
            end
        end
        m_bx = (m_ov[L_BXRST] && m_od[L_BXRST] != 0) ? 0 : m_cnt;
        m_cyc++;
    endtask

    task automatic compare(input string req);
        logic [NL-1:0] a_s, e_s, e_v;
        bit tag_ok;
        int bad_a, bad_e;
        a_s = '0;
        a_s[L_SYNCH] = o_synch; a_s[L_NZS] = o_nzs; a_s[L_SUPP] = o_suppress;
        a_s[L_BXRST] = o_bxrst; a_s[L_FERST] = o_fereset; a_s[L_SNAP] = o_snapshot;
        tag_ok = 1'b1; bad_a = 0; bad_e = 0;
        for (int l = 0; l < NL; l++) begin
            e_v[l] = m_ov[l];
            e_s[l] = (l != L_CALIB) && m_ov[l] && (m_od[l] != 0);
            if (m_ov[l] && int'(o_tag[l*BX_W +: BX_W]) != m_ot[l]) begin
                tag_ok = 1'b0; bad_a = int'(o_tag[l*BX_W +: BX_W]); bad_e = m_ot[l];
            end
        end
        chk(a_s == e_s, req, "strobes", a_s, e_s);
        chk(int'(o_calib) == (m_ov[L_CALIB] ? m_od[L_CALIB] : 0), "R2", "calib",
            o_calib, m_od[L_CALIB]);
        chk(o_tag_vld == e_v, "R6", "tag_vld", o_tag_vld, e_v);
        chk(tag_ok, "R5", "tag", bad_a, bad_e);
        chk(int'(o_bx_local) == m_bx, "R7", "bx_local", o_bx_local, m_bx);
        chk(o_mismatch == m_mis, "R8", "mismatch", o_mismatch, m_mis);
    endtask

    task automatic step(input logic [WORD_W-1:0] w, input string req);
        cmd_word = w;
        @(posedge clk);
        model_edge(w);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({o_synch, o_nzs, o_suppress, o_bxrst, o_fereset, o_snapshot} == '0,
            "R1", "strobes in reset", {o_synch, o_nzs, o_suppress, o_bxrst, o_fereset, o_snapshot}, 0);
        chk(o_calib == '0 && o_tag_vld == '0, "R1", "calib/tag_vld in reset", {o_calib, o_tag_vld}, 0);
        chk(o_bx_local == '0 && !o_mismatch, "R1", "counter/flag in reset", {o_bx_local, o_mismatch}, 0);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic set_all_delays(input int d);
        for (int l = 0; l < NL; l++) cfg_delay[l*DLY_W +: DLY_W] = DLY_W'(d);
    endtask

    function automatic logic [WORD_W-1:0] rnd_word();
        logic [WORD_W-1:0] w;
        w = WORD_W'($urandom);
        w[POS_BXRST] = 1'b0;
        return w;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        do_reset();

        // R3, R5: distinct delay per lane under random traffic
        for (int l = 0; l < NL; l++) cfg_delay[l*DLY_W +: DLY_W] = DLY_W'(4*l + 1);
        for (int i = 0; i < 150; i++) step(rnd_word(), "R3");

        // R3: extreme delays 0 and 31
        for (int l = 0; l < NL; l++) cfg_delay[l*DLY_W +: DLY_W] = (l % 2 == 0) ? 5'd0 : 5'd31;
        for (int i = 0; i < 80; i++) step(rnd_word(), "R3");

        // R4: header-only, veto, both, neither
        set_all_delays(0);
        cfg_delay[L_SUPP*DLY_W +: DLY_W] = 5'd3;
        for (int i = 0; i < 4; i++) begin
            logic [WORD_W-1:0] w;
            w = '0; w[WORD_W-1 -: BX_W] = BX_W'(i + 40);
            w[POS_HDR] = i[0]; w[POS_VETO] = i[1];
            step(w, "R4");
            step('0, "R4");
        end
        cfg_delay[L_SUPP*DLY_W +: DLY_W] = 5'd0;
        for (int i = 0; i < 6; i++) step('0, "R4");

        // R9: synch held for six consecutive words
        set_all_delays(7);
        for (int i = 0; i < 6; i++) begin
            logic [WORD_W-1:0] w;
            w = '0; w[POS_SYNCH] = 1'b1; w[WORD_W-1 -: BX_W] = BX_W'(200 + i);
            step(w, "R9");
        end
        for (int i = 0; i < 20; i++) step('0, "R9");

        // R6: delay shrinks while words are in flight, forcing merges and holes
        set_all_delays(20);
        for (int i = 0; i < 5; i++) step(rnd_word(), "R6");
        set_all_delays(2);
        for (int i = 0; i < 25; i++) step(rnd_word(), "R6");
        set_all_delays(9);
        for (int i = 0; i < 35; i++) step('0, "R6");

        // R2: walk single bits at zero delay, reserved bit included
        set_all_delays(0);
        for (int b = 0; b < CMD_BITS; b++) begin
            logic [WORD_W-1:0] w;
            w = '0; w[b] = 1'b1; w[WORD_W-1 -: BX_W] = BX_W'(b);
            step(w, "R2");
        end
        step('0, "R2");

        // R7, R8: orbit-aligned reset, clean run, then a corrupted crossing
        do_reset();
        set_all_delays(3);
        s = 4090;
        for (int i = 0; i < 80; i++) begin
            logic [WORD_W-1:0] w;
            w = '0;
            w[WORD_W-1 -: BX_W] = (i == 60) ? BX_W'(s + 5) : BX_W'(s);
            w[POS_BXRST] = (s == 0);
            step(w, "R7");
            if (i == 59) chk(!o_mismatch, "R8", "flag before corruption", o_mismatch, 0);
            s = (s + 1) % 4096;
        end
        chk(o_mismatch, "R8", "flag held after corruption", o_mismatch, 1);

        do_reset();
        step('0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule